// File: doc/BRIEF.md
# SPI Transaction Byte Sequencer

This block runs one SPI master transaction at byte granularity. A start pulse captures a transmit byte count, a receive byte count and a filler byte. The block then shifts as many bytes as the larger of the two counts. Transmit bytes come from a request/valid byte source. Once the transmit count is used up, the filler byte is sent instead. Each returned byte is written to a byte sink while the receive count allows, and any returned byte beyond that count is dropped. Each byte goes to a bit-level serial engine through a start/done handshake.

Control pulses can halt the transfer or pause it, always at a byte boundary. Single-cycle event pulses report the start of a transaction, the end of the transmit side, the end of the receive side, normal completion and a halt. A command/data select line marks the first N bytes of each transaction as command bytes. An optional mode restarts the transaction automatically each time it completes. Two amount outputs report how many bytes each side actually moved in the last transaction.

Top module: `spi_byte_seq`

## Requirements
- R1: A transaction shifts exactly max(tx_len, rx_len) bytes through the engine, then completes by itself with one `ev_end_o` pulse and no `ev_stopped_o`.
- R2: The byte at index i (starting at 0) is the i-th byte accepted from the source when i < tx_len; otherwise it is `cfg_orc_i`.
- R3: The engine's return bytes for indices below rx_len are written to the sink in order, one `rx_wr_o` pulse each. Returns at index rx_len or above produce no write.
- R4: `ev_endtx_o` pulses once when byte tx_len-1 completes, and `ev_endrx_o` pulses once when byte rx_len-1 completes. `ev_end_o` pulses one cycle after the last byte completes, and only after both have fired.
- R5: A stop pulse during a transaction lets the byte already handed to the engine finish, starts no further byte, and then pulses `ev_stopped_o`. A stop pulse while idle gives `ev_stopped_o` on the next cycle.
- R6: When a stop completes, any of `ev_endtx_o`/`ev_endrx_o` not yet fired in that transaction pulses in the same cycle as `ev_stopped_o`. `ev_end_o` does not pulse for a stopped transaction.
- R7: A suspend pulse lets the current byte finish and then starts no new byte. A resume pulse continues with the next byte index, and the results are the same as for an uninterrupted transaction.
- R8: `dcx_o` is 0 while bytes with index < N are shifted and 1 for later bytes. N is the 4-bit `cfg_cmd_cnt_i`, and the code 15 makes every byte a command byte.
- R9: The counts and the filler byte are captured in the cycle a transaction starts. Changing them after `ev_started_o` affects only the next transaction.
- R10: With `short_restart_i` high, each `ev_end_o` pulse starts a new transaction, which is reported with `ev_started_o`.
- R11: `tx_amount_o` and `rx_amount_o` are cleared at start and then count the bytes transferred on each side, min(len, bytes shifted). They are 0 after reset.
- R12: `cfg_cmd_cnt_i` is sampled only while idle, so changes during a transaction have no effect on `dcx_o`. `dcx_o` is 1 while idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| suspend_i | input | 1 | Suspend pulse |
| resume_i | input | 1 | Resume pulse |
| short_restart_i | input | 1 | Restart automatically on completion |
| cfg_tx_len_i | input | CNT_W | Transmit byte count (1..65535) |
| cfg_rx_len_i | input | CNT_W | Receive byte count (1..65535) |
| cfg_orc_i | input | BYTE_W | Filler byte |
| cfg_cmd_cnt_i | input | CMD_W | Number of command bytes, all ones means all |
| tx_req_o | output | 1 | Transmit byte request |
| tx_valid_i | input | 1 | Transmit byte valid, consumed when tx_req_o is high |
| tx_data_i | input | BYTE_W | Transmit byte |
| eng_start_o | output | 1 | Pulse: engine shifts eng_data_o |
| eng_data_o | output | BYTE_W | Byte to shift |
| eng_done_i | input | 1 | Engine finished the byte |
| eng_rx_i | input | BYTE_W | Byte returned by the engine, valid with eng_done_i |
| rx_wr_o | output | 1 | Sink write pulse |
| rx_data_o | output | BYTE_W | Sink byte |
| dcx_o | output | 1 | Command (0) / data (1) select |
| ev_started_o | output | 1 | Transaction started pulse |
| ev_endtx_o | output | 1 | Transmit side finished pulse |
| ev_endrx_o | output | 1 | Receive side finished pulse |
| ev_end_o | output | 1 | Transaction completed pulse |
| ev_stopped_o | output | 1 | Halted pulse |
| tx_amount_o | output | CNT_W | Bytes transmitted from the source |
| rx_amount_o | output | CNT_W | Bytes written to the sink |

## Verification
The bench covers unequal counts in both directions. A design that mixed up the counts would send source bytes where filler belongs, or write discarded returns into the sink. Stops and suspends are timed while a byte is inside the engine: a design that cut the byte short would shift too few bytes, and one that lost the forced end events would leave the end-of-side pulses missing. Configuration is changed right after the started pulse and during the automatic restart. This catches a design that reads live settings instead of captured ones, and one whose command/data line follows mid-transaction changes.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_SHIFT = 3'd2,
        S_PAUSE = 3'd3,
        S_FIN   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic started;
        logic endtx;
        logic endrx;
        logic fin;
        logic stopped;
    } seq_ev_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_seq_amount.sv
module spi_seq_amount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_o <= '0;
        else if (inc_i)   cnt_o <= cnt_o + CNT_W'(1);
    end

    // R11: each counted byte adds exactly one
    assert_amount_step_R11: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

endmodule

// File: rtl/spi_seq_dcx.sv
module spi_seq_dcx #(
    parameter int CNT_W = 16,
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic [CMD_W-1:0] cmd_cnt_i,
    output logic             dcx_o
);

    localparam logic [CMD_W-1:0] ALL_CMD = '1;

    logic [CMD_W-1:0] cmd_q;
    logic             is_cmd;

    // setting is sampled only while no transaction runs (R12)
    always_ff @(posedge clk) begin
        if (rst)            cmd_q <= '0;
        else if (!active_i) cmd_q <= cmd_cnt_i;
    end

    always_comb begin
        is_cmd = (cmd_q == ALL_CMD) || (idx_i < CNT_W'(cmd_q));
        dcx_o  = active_i ? !is_cmd : 1'b1;
    end

    // R8/R12: within a transaction the level only moves with the byte index
    assert_dcx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (active_i && $past(active_i) && (idx_i == $past(idx_i))) |-> (dcx_o == $past(dcx_o)));

endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
    import spi_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic              short_i,
    input  logic [CNT_W-1:0]  cfg_tx_len_i,
    input  logic [CNT_W-1:0]  cfg_rx_len_i,
    input  logic [BYTE_W-1:0] cfg_orc_i,
    output logic              tx_req_o,
    input  logic              tx_valid_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              eng_start_o,
    output logic [BYTE_W-1:0] eng_data_o,
    input  logic              eng_done_i,
    input  logic [BYTE_W-1:0] eng_rx_i,
    output logic              rx_wr_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output seq_ev_t           ev_o,
    output logic              active_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic              clr_o,
    output logic              tx_inc_o,
    output logic              rx_inc_o
);

    localparam int CW1 = CNT_W + 1;

    seq_state_t        st;
    logic [CNT_W-1:0]  idx, tx_len_q, rx_len_q, total_q;
    logic [BYTE_W-1:0] orc_q, eng_data_q, rx_data_q;
    logic              eng_start_q, rx_wr_q;
    logic              stop_pend, susp_pend, txdone_f, rxdone_f;
    seq_ev_t           ev_q;

    logic              go, need_tx, last, halt, byte_done;
    logic [CW1-1:0]    idx_p1;

    always_comb begin
        idx_p1    = CW1'(idx) + CW1'(1);
        need_tx   = idx < tx_len_q;
        last      = idx_p1 == CW1'(total_q);
        byte_done = (st == S_SHIFT) && eng_done_i;
        go        = (st == S_IDLE) && !stop_i && (start_i || (ev_q.fin && short_i));
        halt      = ((st == S_FETCH) && stop_pend)
                 || ((st == S_PAUSE) && (stop_pend || stop_i))
                 || (byte_done && (stop_pend || stop_i) && !last);
        tx_req_o  = (st == S_FETCH) && need_tx && !stop_pend && !susp_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            idx         <= '0;
            tx_len_q    <= '0;
            rx_len_q    <= '0;
            total_q     <= '0;
            orc_q       <= '0;
            eng_data_q  <= '0;
            rx_data_q   <= '0;
            eng_start_q <= 1'b0;
            rx_wr_q     <= 1'b0;
            stop_pend   <= 1'b0;
            susp_pend   <= 1'b0;
            txdone_f    <= 1'b0;
            rxdone_f    <= 1'b0;
            ev_q        <= '0;
        end else begin
            eng_start_q <= 1'b0;
            rx_wr_q     <= 1'b0;
            ev_q        <= '0;
            if (stop_i && (st != S_IDLE)) stop_pend <= 1'b1;
            if (suspend_i && ((st == S_FETCH) || (st == S_SHIFT))) susp_pend <= 1'b1;

            unique case (st)
                S_IDLE: begin
                    if (stop_i) begin
                        ev_q.stopped <= 1'b1;
                    end else if (go) begin
                        tx_len_q     <= cfg_tx_len_i;
                        rx_len_q     <= cfg_rx_len_i;
                        total_q      <= CNT_W'(umax(int'(cfg_tx_len_i), int'(cfg_rx_len_i)));
                        orc_q        <= cfg_orc_i;
                        idx          <= '0;
                        txdone_f     <= 1'b0;
                        rxdone_f     <= 1'b0;
                        stop_pend    <= 1'b0;
                        susp_pend    <= 1'b0;
                        ev_q.started <= 1'b1;
                        st           <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (!stop_pend) begin
                        if (susp_pend) begin
                            st <= S_PAUSE;
                        end else if (!need_tx || tx_valid_i) begin
                            eng_data_q  <= need_tx ? tx_data_i : orc_q;
                            eng_start_q <= 1'b1;
                            st          <= S_SHIFT;
                        end
                    end
                end
                S_SHIFT: begin
                    if (eng_done_i) begin
                        idx <= CNT_W'(idx_p1);
                        if (idx < rx_len_q) begin
                            rx_wr_q   <= 1'b1;
                            rx_data_q <= eng_rx_i;
                        end
                        if (!txdone_f && (idx_p1 == CW1'(tx_len_q))) begin
                            ev_q.endtx <= 1'b1;
                            txdone_f   <= 1'b1;
                        end
                        if (!rxdone_f && (idx_p1 == CW1'(rx_len_q))) begin
                            ev_q.endrx <= 1'b1;
                            rxdone_f   <= 1'b1;
                        end
                        if (last)                          st <= S_FIN;
                        else if (susp_pend || suspend_i)   st <= S_PAUSE;
                        else                               st <= S_FETCH;
                    end
                end
                S_PAUSE: begin
                    if (resume_i) begin
                        susp_pend <= 1'b0;
                        st        <= S_FETCH;
                    end
                end
                S_FIN: begin
                    ev_q.fin <= 1'b1;
                    if (stop_pend || stop_i) ev_q.stopped <= 1'b1;
                    stop_pend <= 1'b0;
                    susp_pend <= 1'b0;
                    st        <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase

            // graceful halt with forced side-end events (R5, R6)
            if (halt) begin
                st           <= S_IDLE;
                ev_q.stopped <= 1'b1;
                ev_q.endtx   <= !txdone_f;
                ev_q.endrx   <= !rxdone_f;
                txdone_f     <= 1'b1;
                rxdone_f     <= 1'b1;
                stop_pend    <= 1'b0;
                susp_pend    <= 1'b0;
            end
        end
    end

    always_comb begin
        eng_start_o = eng_start_q;
        eng_data_o  = eng_data_q;
        rx_wr_o     = rx_wr_q;
        rx_data_o   = rx_data_q;
        ev_o        = ev_q;
        active_o    = (st == S_FETCH) || (st == S_SHIFT) || (st == S_PAUSE);
        idx_o       = idx;
        clr_o       = go;
        tx_inc_o    = byte_done && need_tx;
        rx_inc_o    = byte_done && (idx < rx_len_q);
    end

    // R4: completion only after both sides have reported
    assert_end_after_both_R4: assert property (@(posedge clk) disable iff (rst)
        ev_q.fin |-> (txdone_f && rxdone_f));

    // R3: a sink write never takes the index past the receive count
    assert_rx_bound_R3: assert property (@(posedge clk) disable iff (rst)
        rx_wr_q |-> (idx <= rx_len_q));

    // R5: stop while idle answers on the next cycle
    assert_stop_idle_R5: assert property (@(posedge clk) disable iff (rst)
        ((st == S_IDLE) && stop_i) |=> ev_q.stopped);

    // R7: a paused transfer stays paused until resume or stop
    assert_pause_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((st == S_PAUSE) && !resume_i && !stop_i && !stop_pend) |=> (st == S_PAUSE));

    // R1: normal completion after exactly the larger count
    assert_total_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_FIN) |-> (idx == total_q));

endmodule

// File: rtl/spi_byte_seq.sv
module spi_byte_seq
    import spi_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic              short_restart_i,
    input  logic [CNT_W-1:0]  cfg_tx_len_i,
    input  logic [CNT_W-1:0]  cfg_rx_len_i,
    input  logic [BYTE_W-1:0] cfg_orc_i,
    input  logic [CMD_W-1:0]  cfg_cmd_cnt_i,
    output logic              tx_req_o,
    input  logic              tx_valid_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              eng_start_o,
    output logic [BYTE_W-1:0] eng_data_o,
    input  logic              eng_done_i,
    input  logic [BYTE_W-1:0] eng_rx_i,
    output logic              rx_wr_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              dcx_o,
    output logic              ev_started_o,
    output logic              ev_endtx_o,
    output logic              ev_endrx_o,
    output logic              ev_end_o,
    output logic              ev_stopped_o,
    output logic [CNT_W-1:0]  tx_amount_o,
    output logic [CNT_W-1:0]  rx_amount_o
);

    localparam int NSIDE = 2;

    seq_ev_t          ev;
    logic             active, clr, tx_inc, rx_inc;
    logic [CNT_W-1:0] idx;
    logic [NSIDE-1:0] side_inc;
    logic [CNT_W-1:0] side_cnt [NSIDE];

    spi_seq_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) core_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .suspend_i    (suspend_i),
        .resume_i     (resume_i),
        .short_i      (short_restart_i),
        .cfg_tx_len_i (cfg_tx_len_i),
        .cfg_rx_len_i (cfg_rx_len_i),
        .cfg_orc_i    (cfg_orc_i),
        .tx_req_o     (tx_req_o),
        .tx_valid_i   (tx_valid_i),
        .tx_data_i    (tx_data_i),
        .eng_start_o  (eng_start_o),
        .eng_data_o   (eng_data_o),
        .eng_done_i   (eng_done_i),
        .eng_rx_i     (eng_rx_i),
        .rx_wr_o      (rx_wr_o),
        .rx_data_o    (rx_data_o),
        .ev_o         (ev),
        .active_o     (active),
        .idx_o        (idx),
        .clr_o        (clr),
        .tx_inc_o     (tx_inc),
        .rx_inc_o     (rx_inc)
    );

    spi_seq_dcx #(.CNT_W(CNT_W), .CMD_W(CMD_W)) dcx_i (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .idx_i     (idx),
        .cmd_cnt_i (cfg_cmd_cnt_i),
        .dcx_o     (dcx_o)
    );

    assign side_inc = {rx_inc, tx_inc};

    for (genvar s = 0; s < NSIDE; s++) begin : g_amount
        spi_seq_amount #(.CNT_W(CNT_W)) amt_i (
            .clk   (clk),
            .rst   (rst),
            .clr_i (clr),
            .inc_i (side_inc[s]),
            .cnt_o (side_cnt[s])
        );
    end

    assign tx_amount_o  = side_cnt[0];
    assign rx_amount_o  = side_cnt[1];
    assign ev_started_o = ev.started;
    assign ev_endtx_o   = ev.endtx;
    assign ev_endrx_o   = ev.endrx;
    assign ev_end_o     = ev.fin;
    assign ev_stopped_o = ev.stopped;

endmodule

// File: tb/spi_byte_seq_tb_top.sv
module spi_byte_seq_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        start_i = 0, stop_i = 0, suspend_i = 0, resume_i = 0, short_restart_i = 0;
    logic [15:0] cfg_tx_len_i = 16'd1, cfg_rx_len_i = 16'd1;
    logic [7:0]  cfg_orc_i = 8'h00;
    logic [3:0]  cfg_cmd_cnt_i = 4'd0;
    logic        tx_req_o, tx_valid_i = 0, eng_start_o, eng_done_i = 0, rx_wr_o, dcx_o;
    logic [7:0]  tx_data_i = 0, eng_data_o, eng_rx_i = 0, rx_data_o;
    logic        ev_started_o, ev_endtx_o, ev_endrx_o, ev_end_o, ev_stopped_o;
    logic [15:0] tx_amount_o, rx_amount_o;

    spi_byte_seq dut_i (.*);

    int nchk = 0, nfail = 0;
    logic [7:0] sent_log [0:255];
    logic       dcx_log  [0:255];
    logic [7:0] rx_log   [0:255];
    int ns = 0, nr = 0, txk = 0, cd = 0;
    int c_started = 0, c_endtx = 0, c_endrx = 0, c_end = 0, c_stopped = 0;

    function automatic logic [7:0] txpat(input int k);
        return 8'((k * 13 + 65) & 255);
    endfunction
    function automatic logic [7:0] rxpat(input int i);
        return 8'(((i * 29 + 3) & 255) ^ 8'h5A);
    endfunction
    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bench models: byte source, serial engine, sink and event monitor
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            c_started += int'(ev_started_o);
            c_endtx   += int'(ev_endtx_o);
            c_endrx   += int'(ev_endrx_o);
            c_end     += int'(ev_end_o);
            c_stopped += int'(ev_stopped_o);
            if (rx_wr_o) begin rx_log[nr] = rx_data_o; nr++; end
            if (tx_valid_i) txk++;
            if (tx_req_o && ($urandom % 4 != 0)) begin
                tx_valid_i = 1'b1;
                tx_data_i  = txpat(txk);
            end else begin
                tx_valid_i = 1'b0;
            end
            eng_done_i = 1'b0;
            if (eng_start_o) begin
                sent_log[ns] = eng_data_o;
                dcx_log[ns]  = dcx_o;
                ns++;
                cd = 1 + int'($urandom % 3);
            end else if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    eng_done_i = 1'b1;
                    eng_rx_i   = rxpat(ns - 1);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic clear_logs();
        ns = 0; nr = 0; txk = 0;
        c_started = 0; c_endtx = 0; c_endrx = 0; c_end = 0; c_stopped = 0;
    endtask

    task automatic wait_ns(input int k);
        int t = 0;
        while (ns < k && t < 3000) begin step(); t++; end
        check(t < 3000, "timeout", t, 0);
    endtask

    task automatic wait_done();
        int t = 0;
        while ((c_end + c_stopped) == 0 && t < 3000) begin step(); t++; end
        check(t < 3000, "timeout", t, 0);
        repeat (3) step();
    endtask

    // mode 0 normal, 1 stop after byte k starts, 2 suspend after byte k starts
    task automatic run_txn(input int tx, input int rx, input int cmd, input logic [7:0] orc,
                           input int mode, input int k);
        int total, bad;
        clear_logs();
        cfg_tx_len_i = 16'(tx); cfg_rx_len_i = 16'(rx);
        cfg_cmd_cnt_i = 4'(cmd); cfg_orc_i = orc;
        start_i = 1; step(); start_i = 0;
        step();
        // R9, R12: disturb the settings once the transaction has started
        cfg_tx_len_i = 16'd40; cfg_rx_len_i = 16'd40;
        cfg_cmd_cnt_i = ~4'(cmd); cfg_orc_i = ~orc;
        if (mode == 1) begin
            wait_ns(k);
            stop_i = 1; step(); stop_i = 0;
        end else if (mode == 2) begin
            wait_ns(k);
            suspend_i = 1; step(); suspend_i = 0;
            repeat (25) step();
            check(ns == k, "R7 paused byte count", ns, k);
            check(c_end == 0 && c_stopped == 0, "R7 no end while paused", c_end, 0);
            resume_i = 1; step(); resume_i = 0;
        end
        wait_done();
        total = (mode == 1) ? k : imax(tx, rx);
        check(ns == total, "R1 bytes shifted", ns, total);
        bad = 0;
        for (int i = 0; i < ns && i < 256; i++)
            if (sent_log[i] != ((i < tx) ? txpat(i) : orc)) bad++;
        check(bad == 0, "R2 transmit byte order and filler", bad, 0);
        check(nr == imin(rx, total), "R3 sink write count", nr, imin(rx, total));
        bad = 0;
        for (int i = 0; i < nr && i < 256; i++)
            if (rx_log[i] != rxpat(i)) bad++;
        check(bad == 0, "R3 sink data", bad, 0);
        bad = 0;
        for (int i = 0; i < ns && i < 256; i++)
            if (dcx_log[i] != !((cmd == 15) || (i < cmd))) bad++;
        check(bad == 0, "R8 dcx level per byte (R12 mid change ignored)", bad, 0);
        check(c_endtx == 1 && c_endrx == 1, "R4 R6 side end events", c_endtx * 10 + c_endrx, 11);
        check(c_end == ((mode == 1) ? 0 : 1), "R4 R6 end event", c_end, (mode == 1) ? 0 : 1);
        check(c_stopped == ((mode == 1) ? 1 : 0), "R5 stopped event", c_stopped, (mode == 1) ? 1 : 0);
        check(c_started == 1, "R9 started once", c_started, 1);
        check(int'(tx_amount_o) == imin(tx, total), "R11 tx amount", int'(tx_amount_o), imin(tx, total));
        check(int'(rx_amount_o) == imin(rx, total), "R11 rx amount", int'(rx_amount_o), imin(rx, total));
        check(dcx_o == 1'b1, "R12 idle dcx", int'(dcx_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual 150000 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) step();
        rst = 0;
        step();
        // reset state
        check(dcx_o == 1'b1, "R12 reset dcx", int'(dcx_o), 1);
        check(tx_amount_o == 0 && rx_amount_o == 0, "R11 reset amounts", int'(tx_amount_o), 0);
        check(!tx_req_o && !eng_start_o && !rx_wr_o, "R1 reset quiet", int'(tx_req_o), 0);
        check(!(ev_started_o | ev_endtx_o | ev_endrx_o | ev_end_o | ev_stopped_o),
              "R4 reset events", 1, 0);

        // stop while idle
        clear_logs();
        stop_i = 1; step(); stop_i = 0;
        repeat (3) step();
        check(c_stopped == 1, "R5 idle stop", c_stopped, 1);
        check(c_end == 0 && c_endtx == 0 && c_endrx == 0, "R6 idle stop no side events", c_endtx, 0);

        // directed corners
        run_txn(1, 1, 0, 8'hFF, 0, 0);
        run_txn(5, 2, 2, 8'h3C, 0, 0);    // receive discard
        run_txn(2, 6, 15, 8'hC3, 0, 0);   // filler, all command bytes
        run_txn(3, 8, 1, 8'h99, 1, 2);    // stop mid transfer
        run_txn(7, 2, 4, 8'h11, 1, 4);    // stop after rx side done
        run_txn(4, 9, 3, 8'h77, 2, 5);    // suspend past the tx side

        // random mix
        for (int n = 0; n < 10; n++) begin
            int tx = 1 + int'($urandom % 10);
            int rx = 1 + int'($urandom % 10);
            int cm = int'($urandom % 16);
            int tot = imax(tx, rx);
            int md = (tot > 2) ? int'($urandom % 3) : 0;
            int kk = (tot > 2) ? 1 + int'($urandom % (tot - 2)) : 0;
            run_txn(tx, rx, cm, 8'($urandom), md, kk);
        end

        // R10 shortcut restart, R9 new counts for the next transaction
        clear_logs();
        cfg_tx_len_i = 16'd3; cfg_rx_len_i = 16'd2; cfg_orc_i = 8'hE5; cfg_cmd_cnt_i = 4'd0;
        short_restart_i = 1;
        start_i = 1; step(); start_i = 0;
        while (c_started < 1) step();
        cfg_tx_len_i = 16'd1; cfg_rx_len_i = 16'd4;
        begin
            int t = 0;
            while (c_started < 2 && t < 3000) begin step(); t++; end
            short_restart_i = 0;
            while (c_end < 2 && t < 3000) begin step(); t++; end
            check(t < 3000, "timeout", t, 0);
        end
        repeat (3) step();
        check(c_end == 2 && c_started == 2, "R10 restart on end", c_started, 2);
        check(ns == 7, "R10 R9 bytes over two transactions", ns, 7);
        check(sent_log[3] == txpat(3) && sent_log[4] == 8'hE5, "R9 new counts applied",
              int'(sent_log[4]), 8'hE5);
        check(nr == 6, "R9 R3 sink writes", nr, 6);
        check(int'(rx_amount_o) == 4 && int'(tx_amount_o) == 1, "R11 amounts of last", int'(rx_amount_o), 4);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule